// File: doc/BRIEF.md
# Programmable Reset Release Sequencer

This block drives the chip's main active-low system reset from two active-low reset inputs. One input clears the always-on standby domain. The other clears the working domain. While either input is low, the system reset is low at once, with no clock needed. Once both inputs are high, a counter clocked by the 32.768 kHz slow clock measures a programmable hold time. The resulting "done" flag then crosses into the bus clock domain, and the system reset is released on a rising bus-clock edge.

The hold time is kept in a 20-bit register, counted in slow-clock ticks. Only the standby reset clears this register, back to its default of 262 ticks (about 8 ms). Software can therefore write a new value, pulse the working reset, and have the next release use the new value. The longest setting is 1,048,575 ticks, about 32 s.

Two state machines make up the block. The slow-domain sequencer has three states. ARM is held while in reset. On the first slow edge out of reset it moves ARM→COUNT and latches the target. COUNT→DONE happens when the count reaches the target, and DONE holds. The bus-domain release stage has two states: HOLD→RELEASED when the synchronized done flag is seen, and RELEASED holds until the next reset.

Top module: `rst_release_seq`

## Requirements
- R1: `sys_rst_n` is low whenever `stby_rst_n` or `work_rst_n` is low, and it goes low without waiting for any clock edge.
- R2: After `stby_rst_n` has been low, the hold time is the default of 262 slow ticks.
- R3: Count slow-clock rising edges strictly after both inputs are high, with programmed hold D. The done flag rises on edge D+4: two synchronizer edges, one arm edge, then D+1 counting edges. `sys_rst_n` then rises on the third bus-clock rising edge after the done flag rises.
- R4: `sys_rst_n` only goes high on a bus-clock rising edge, and only after the synchronized done flag was high at the previous edge.
- R5: A working-domain reset leaves the programmed hold value unchanged. Only a standby reset reloads the default.
- R6: A low pulse of 10 ns on `work_rst_n` is recognised, even with no slow-clock edge during the pulse, and restarts the sequence.
- R7: A new assertion of either reset while the count runs drops `sys_rst_n` immediately, and counting restarts from zero after release.
- R8: A write while the count runs does not change the current count target. The new value is used from the next reset.
- R9: A programmed hold of zero sets the done flag on slow edge 4 after release.
- R10: The write port is sampled on the slow-clock rising edge when `cfg_wr_en` is high. The whole 20-bit `cfg_wr_data` field becomes the hold value. Writes are accepted only once the synchronized standby reset has released, i.e. from the third slow edge after `stby_rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock; the system reset is released on its rising edge |
| slow_clk | input | 1 | 32.768 kHz slow clock for counting and register writes |
| stby_rst_n | input | 1 | Active-low standby-domain reset; also reloads the default hold value |
| work_rst_n | input | 1 | Active-low working-domain reset |
| cfg_wr_en | input | 1 | Write strobe for the hold register, sampled on slow_clk |
| cfg_wr_data | input | 20 | New hold value in slow ticks |
| sys_rst_n | output | 1 | Active-low system reset output |

## Verification
Two events can fall in the same cycle. A reset can be re-asserted while the slow counter is mid-count. A hold-register write can also land in the slow cycle where the sequencer is counting, or in the cycle where it arms. The bench provokes both with short working-reset pulses and with writes placed a few slow edges into a count. A behavioural model tracks edge counts since release and the latched target, and the output is compared with it at every bus clock. A write or pulse that is handled wrongly therefore shows up as a release at the wrong edge.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    typedef enum logic [1:0] {
        SEQ_ARM   = 2'b00,
        SEQ_COUNT = 2'b01,
        SEQ_DONE  = 2'b10
    } seq_state_t;

    typedef enum logic {
        REL_HOLD     = 1'b0,
        REL_RELEASED = 1'b1
    } rel_state_t;

endpackage

// File: rtl/rrs_sync.sv
module rrs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) chain[0] <= 1'b0;
                    else         chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) chain[i] <= 1'b0;
                    else         chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[LAST];
endmodule

// File: rtl/rrs_delay_reg.sv
module rrs_delay_reg #(
    parameter int          DELAY_W       = 20,
    parameter logic [19:0] DELAY_DEFAULT = 20'd262
) (
    input  logic               clk,
    input  logic               arst_n,
    input  logic               wr_en,
    input  logic [DELAY_W-1:0] wr_data,
    output logic [DELAY_W-1:0] delay_q
);
    localparam logic [DELAY_W-1:0] RESET_VAL = DELAY_W'(DELAY_DEFAULT);

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)    delay_q <= RESET_VAL;
        else if (wr_en) delay_q <= wr_data;
    end
endmodule

// File: rtl/rrs_slow_seq.sv
module rrs_slow_seq
    import rrs_pkg::*;
#(
    parameter int DELAY_W = 20
) (
    input  logic               clk,
    input  logic               arst_n,
    input  logic [DELAY_W-1:0] delay_in,
    output logic               done,
    output seq_state_t         state_o,
    output logic [DELAY_W-1:0] cnt_o,
    output logic [DELAY_W-1:0] target_o
);
    seq_state_t         state, state_nxt;
    logic [DELAY_W-1:0] cnt, target;
    logic               reached;

    assign reached = (cnt == target);

    // state register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state <= SEQ_ARM;
        else         state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            SEQ_ARM:   state_nxt = SEQ_COUNT;
            SEQ_COUNT: state_nxt = reached ? SEQ_DONE : SEQ_COUNT;
            SEQ_DONE:  state_nxt = SEQ_DONE;
            default:   state_nxt = SEQ_ARM;
        endcase
    end

    // counter and latched target
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt    <= '0;
            target <= '0;
        end else if (state == SEQ_ARM) begin
            cnt    <= '0;
            target <= delay_in;
        end else if (state == SEQ_COUNT && !reached) begin
            cnt    <= cnt + 1'b1;
        end
    end

    // registered output
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) done <= 1'b0;
        else         done <= (state_nxt == SEQ_DONE);
    end

    assign state_o  = state;
    assign cnt_o    = cnt;
    assign target_o = target;
endmodule

// File: rtl/rrs_bus_release.sv
module rrs_bus_release
    import rrs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic done_async,
    output logic done_bus,
    output logic sys_rst_n
);
    rel_state_t state, state_nxt;

    rrs_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d      (done_async),
        .q      (done_bus)
    );

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state <= REL_HOLD;
        else         state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            REL_HOLD:     state_nxt = done_bus ? REL_RELEASED : REL_HOLD;
            REL_RELEASED: state_nxt = REL_RELEASED;
            default:      state_nxt = REL_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sys_rst_n <= 1'b0;
        else         sys_rst_n <= (state_nxt == REL_RELEASED);
    end
endmodule

// File: rtl/rst_release_seq.sv
module rst_release_seq
    import rrs_pkg::*;
#(
    parameter int          DELAY_W       = 20,
    parameter logic [19:0] DELAY_DEFAULT = 20'd262,
    parameter int          SYNC_STAGES   = 2
) (
    input  logic               bus_clk,
    input  logic               slow_clk,
    input  logic               stby_rst_n,
    input  logic               work_rst_n,
    input  logic               cfg_wr_en,
    input  logic [DELAY_W-1:0] cfg_wr_data,
    output logic               sys_rst_n
);
    logic               rst_any_n;
    logic               slow_rst_n;
    logic               stby_sync_n;
    logic [DELAY_W-1:0] delay_q;
    logic               done_slow;
    logic               done_bus;
    seq_state_t         seq_state;
    logic [DELAY_W-1:0] seq_cnt;
    logic [DELAY_W-1:0] seq_target;

    assign rst_any_n = stby_rst_n & work_rst_n;

    rrs_sync #(.STAGES(SYNC_STAGES)) u_any_sync (
        .clk    (slow_clk),
        .arst_n (rst_any_n),
        .d      (1'b1),
        .q      (slow_rst_n)
    );

    rrs_sync #(.STAGES(SYNC_STAGES)) u_stby_sync (
        .clk    (slow_clk),
        .arst_n (stby_rst_n),
        .d      (1'b1),
        .q      (stby_sync_n)
    );

    rrs_delay_reg #(
        .DELAY_W       (DELAY_W),
        .DELAY_DEFAULT (DELAY_DEFAULT)
    ) u_delay (
        .clk     (slow_clk),
        .arst_n  (stby_sync_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .delay_q (delay_q)
    );

    rrs_slow_seq #(.DELAY_W(DELAY_W)) u_seq (
        .clk      (slow_clk),
        .arst_n   (slow_rst_n),
        .delay_in (delay_q),
        .done     (done_slow),
        .state_o  (seq_state),
        .cnt_o    (seq_cnt),
        .target_o (seq_target)
    );

    rrs_bus_release #(.SYNC_STAGES(SYNC_STAGES)) u_rel (
        .clk        (bus_clk),
        .arst_n     (rst_any_n),
        .done_async (done_slow),
        .done_bus   (done_bus),
        .sys_rst_n  (sys_rst_n)
    );
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker
    import rrs_pkg::*;
#(
    parameter int DELAY_W = 20
) (
    input logic               bus_clk,
    input logic               slow_clk,
    input logic               stby_rst_n,
    input logic               work_rst_n,
    input logic               rst_any_n,
    input logic               slow_rst_n,
    input logic               stby_sync_n,
    input logic               cfg_wr_en,
    input logic [DELAY_W-1:0] delay_q,
    input seq_state_t         seq_state,
    input logic [DELAY_W-1:0] seq_cnt,
    input logic [DELAY_W-1:0] seq_target,
    input logic               done_bus,
    input logic               sys_rst_n
);
    // R1: output held low while the working reset is low
    a_r1_low_in_reset: assert property (@(posedge bus_clk) disable iff (!stby_rst_n)
        !work_rst_n |-> !sys_rst_n);

    // R4: release only after the synchronized done flag was seen
    a_r4_release_after_done: assert property (@(posedge bus_clk) disable iff (!rst_any_n)
        $rose(sys_rst_n) |-> $past(done_bus));

    // R8: latched target does not move while counting
    a_r8_target_stable: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        (seq_state == SEQ_COUNT && $past(seq_state) == SEQ_COUNT) |-> $stable(seq_target));

    // R7: count never passes its target
    a_r7_count_bounded: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        (seq_state == SEQ_COUNT) |-> (seq_cnt <= seq_target));

    // R3: done state is held until reset
    a_r3_done_sticky: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        (seq_state == SEQ_DONE) |=> (seq_state == SEQ_DONE));

    // R5: hold value changes only through a write
    a_r5_delay_hold: assert property (@(posedge slow_clk) disable iff (!stby_sync_n)
        !cfg_wr_en |=> $stable(delay_q));
endmodule

bind rst_release_seq rrs_checker #(.DELAY_W(DELAY_W)) u_chk (
    .bus_clk     (bus_clk),
    .slow_clk    (slow_clk),
    .stby_rst_n  (stby_rst_n),
    .work_rst_n  (work_rst_n),
    .rst_any_n   (rst_any_n),
    .slow_rst_n  (slow_rst_n),
    .stby_sync_n (stby_sync_n),
    .cfg_wr_en   (cfg_wr_en),
    .delay_q     (delay_q),
    .seq_state   (seq_state),
    .seq_cnt     (seq_cnt),
    .seq_target  (seq_target),
    .done_bus    (done_bus),
    .sys_rst_n   (sys_rst_n)
);

// File: tb/rst_release_seq_tb.sv
`timescale 1ns/1ps
module rst_release_seq_tb;
    logic        bus_clk = 1'b0;
    logic        slow_clk = 1'b0;
    logic        stby_rst_n = 1'b0;
    logic        work_rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [19:0] cfg_wr_data = '0;
    logic        sys_rst_n;

    int checks = 0;
    int errors = 0;
    bit started = 1'b0;
    string cur_req = "R1";

    // reference model state
    int  se = 0;          // slow edges since both resets high
    int  sb = 0;          // slow edges since standby release
    int  ba = 0;          // bus edges since model done
    int  m_delay = 262;
    int  m_tgt = 0;
    bit  m_done = 1'b0;
    bit  m_out = 1'b0;
    logic any_n;

    assign any_n = stby_rst_n & work_rst_n;

    rst_release_seq u_dut (
        .bus_clk     (bus_clk),
        .slow_clk    (slow_clk),
        .stby_rst_n  (stby_rst_n),
        .work_rst_n  (work_rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .sys_rst_n   (sys_rst_n)
    );

    always #10 bus_clk = ~bus_clk;
    initial begin
        #5;
        forever #80 slow_clk = ~slow_clk;
    end

    always @(negedge stby_rst_n) begin
        m_delay = 262;
        sb = 0;
    end

    always @(negedge any_n) begin
        se = 0; ba = 0; m_done = 1'b0; m_out = 1'b0;
    end

    always @(posedge slow_clk) begin
        if (stby_rst_n) sb++;
        if (any_n) begin
            se++;
            if (se == 3) m_tgt = m_delay;
            if (se >= 4 && se == 4 + m_tgt) m_done = 1'b1;
        end
        if (cfg_wr_en && stby_rst_n && sb >= 3) m_delay = int'(cfg_wr_data);
    end

    always @(posedge bus_clk) begin
        if (any_n && m_done) begin
            ba++;
            if (ba == 3) m_out = 1'b1;
        end
    end

    // per-clock comparison against the model
    always @(negedge bus_clk) begin
        if (started) begin
            checks++;
            if (sys_rst_n !== m_out) begin
                errors++;
                $display("FAIL %s: sys_rst_n=%b expected %b at %0t", cur_req, sys_rst_n, m_out, $time);
            end
        end
    end

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_write(input logic [19:0] v);
        @(negedge slow_clk);
        cfg_wr_en = 1'b1; cfg_wr_data = v;
        @(negedge slow_clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic pulse_work(input int w, input string req);
        @(negedge bus_clk);
        #3 work_rst_n = 1'b0;
        #(w / 2);
        check(sys_rst_n == 1'b0, req, int'(sys_rst_n), 0);
        #(w - w / 2) work_rst_n = 1'b1;
    endtask

    task automatic wait_release(input string req);
        int n;
        n = 0;
        while (m_out == 1'b0 && n < 20000) begin
            @(negedge bus_clk);
            n++;
        end
        repeat (3) @(negedge bus_clk);
        check(sys_rst_n == 1'b1, req, int'(sys_rst_n), 1);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge bus_clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge bus_clk);
        started = 1'b1;
        // R1: reset state
        check(sys_rst_n == 1'b0, "R1", int'(sys_rst_n), 0);

        // R2/R3: default hold after standby reset
        cur_req = "R2";
        #3; stby_rst_n = 1'b1; work_rst_n = 1'b1;
        wait_release("R2");

        // R10: write while released has no visible effect yet
        cur_req = "R10";
        do_write(20'd5);
        check(sys_rst_n == 1'b1, "R10", int'(sys_rst_n), 1);

        // R5: working reset keeps programmed value (5)
        cur_req = "R5";
        pulse_work(30, "R1");
        wait_release("R5");

        // R8: write during count is deferred
        cur_req = "R8";
        pulse_work(30, "R1");
        repeat (5) @(posedge slow_clk);
        do_write(20'd2);
        wait_release("R8");
        pulse_work(30, "R8");
        wait_release("R8");

        // R7 and R6: reassert mid-count with a 10 ns pulse
        cur_req = "R7";
        pulse_work(30, "R7");
        repeat (4) @(posedge slow_clk);
        cur_req = "R6";
        pulse_work(10, "R6");
        wait_release("R7");

        // R9: zero hold
        cur_req = "R9";
        do_write(20'd0);
        pulse_work(30, "R9");
        wait_release("R9");

        // R3: standby reset restores default, timing exact per model
        cur_req = "R3";
        @(negedge bus_clk);
        #3 stby_rst_n = 1'b0;
        #20;
        check(sys_rst_n == 1'b0, "R1", int'(sys_rst_n), 0);
        stby_rst_n = 1'b1;
        wait_release("R3");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule